// File: doc/BRIEF.md
# Legacy Peripheral I/O Chip-Select Decoder

This block watches a 16-bit I/O address together with read and write strobes and turns each access into a select for one of the classic motherboard peripherals: keyboard controller, real-time clock, disk controller (IDE), floppy controller, parallel port, two serial ports, configuration RAM and the port-92 control latch. It also drives one shared output enable for the transceiver that links those peripherals to the system data bus, and a pair of read and write strobes for the configuration RAM.

Two 8-bit control registers, written through a simple write port (`cfg_we`, `cfg_sel`, `cfg_wdata`), choose which peripherals decode and at which address window. Control register A (`cfg_sel`=0) holds enables and range picks for the keyboard, clock, IDE and floppy. Control register B (`cfg_sel`=1) holds small encoded fields for the parallel and serial ports, plus enables for configuration RAM and port 92. Selects are combinational from the current address, strobes and register contents. No data flows through the block, so it has no valid/ready handshake and no back-pressure: every pin is a plain level-sensitive control signal.

Top module: `legacy_iocs_decoder`

## Requirements
- R1: After reset, register A holds 04h and register B holds 7Fh. Only primary floppy and port 92 decode; the serial ports, parallel port, keyboard, clock, IDE and configuration RAM are off.
- R2: With A[1]=1, an access to 60h or 64h asserts `cs_kbd`. With parameter KBD_ALT_PORTS=1, 62h and 66h also assert it. With A[1]=0, none of these addresses assert `cs_kbd` or `xcvr_oe`.
- R3: With A[6]=1 and A[1]=1, keyboard accesses assert `cs_kbd` and leave `xcvr_oe` low. A[6] has no effect while A[1]=0.
- R4: With A[0]=1, accesses to 70h–77h assert `cs_rtc`.
- R5: With A[4]=1, `cs_ide` is asserted for 1F0h–1F7h, 3F6h and 3F7h when A[5]=0. When A[5]=1 it is asserted for 170h–177h, 376h and 377h instead.
- R6: Accesses to 3F7h and 377h always assert `xcvr_oe`, including when A[4]=0.
- R7: A[2]=1 asserts `cs_fdc` for 3F0h–3F5h. A[3]=1 asserts `cs_fdc` for 370h–375h.
- R8: Field B[5:4] picks the window for `cs_lpt`: 00 gives 3BCh–3BFh, 01 gives 378h–37Fh, 10 gives 278h–27Fh, 11 gives nothing.
- R9: Field B[1:0] drives `cs_com_a` and field B[3:2] drives `cs_com_b`. Code 00 gives 3F8h–3FFh, 01 gives 2F8h–2FFh, and 10 (reserved) and 11 give nothing.
- R10: With B[7]=1, `cs_cram` is asserted for reads and writes to 0800h–08FFh and for writes to 0C00h. `cram_rd` and `cram_wr` follow `io_rd` and `io_wr` only inside 0800h–08FFh.
- R11: With B[6]=1, accesses to 0092h assert `cs_p92`.
- R12: Every asserted select except a mapped keyboard select also asserts `xcvr_oe`. No output is asserted unless `io_rd` or `io_wr` is high. All address bits take part in the decode, so there is no aliasing above 0FFFh.
- R13: A write with `cfg_we`=1 loads `cfg_wdata` into register A (`cfg_sel`=0) or register B (`cfg_sel`=1) at the clock edge, and the new decode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| cfg_we | input | 1 | Control register write enable |
| cfg_sel | input | 1 | 0 = register A, 1 = register B |
| cfg_wdata | input | 8 | Control register write data |
| cs_kbd | output | 1 | Keyboard controller select |
| cs_rtc | output | 1 | Real-time clock select |
| cs_ide | output | 1 | IDE controller select |
| cs_fdc | output | 1 | Floppy controller select |
| cs_lpt | output | 1 | Parallel port select |
| cs_com_a | output | 1 | Serial port A select |
| cs_com_b | output | 1 | Serial port B select |
| cs_cram | output | 1 | Configuration RAM select |
| cs_p92 | output | 1 | Port 92 select |
| xcvr_oe | output | 1 | Shared peripheral transceiver enable |
| cram_rd | output | 1 | Configuration RAM read strobe |
| cram_wr | output | 1 | Configuration RAM write strobe |

## Verification
The bench builds the block with its defaults: ADDR_W=16 and KBD_ALT_PORTS=1, so the alternate keyboard ports 62h and 66h are in the decode. At that size, every address from 000h to FFFh can be swept once for reads and once for writes under a handful of register settings. The settings cover every code of each encoded field, including the reserved serial code, both IDE ranges and the keyboard mapping bit. A further sweep with bit 15 set shows that no window aliases into the upper address space, and a short pass with both strobes low shows that nothing decodes without an access.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  localparam int REG_W  = 8;
  localparam int NSEL   = 9;
  localparam int S_KBD  = 0;
  localparam int S_RTC  = 1;
  localparam int S_IDE  = 2;
  localparam int S_FDC  = 3;
  localparam int S_LPT  = 4;
  localparam int S_COMA = 5;
  localparam int S_COMB = 6;
  localparam int S_CRAM = 7;
  localparam int S_P92  = 8;

  typedef enum logic [1:0] {
    LPT_3BC = 2'b00,
    LPT_378 = 2'b01,
    LPT_278 = 2'b10,
    LPT_OFF = 2'b11
  } lpt_map_e;

  typedef enum logic [1:0] {
    COM_3F8  = 2'b00,
    COM_2F8  = 2'b01,
    COM_RSVD = 2'b10,
    COM_OFF  = 2'b11
  } com_map_e;

  function automatic logic in_rng(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic lpt_hit(logic [31:0] a, lpt_map_e m);
    case (m)
      LPT_3BC: return in_rng(a, 32'h3BC, 32'h3BF);
      LPT_378: return in_rng(a, 32'h378, 32'h37F);
      LPT_278: return in_rng(a, 32'h278, 32'h27F);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic com_hit(logic [31:0] a, com_map_e m);
    case (m)
      COM_3F8: return in_rng(a, 32'h3F8, 32'h3FF);
      COM_2F8: return in_rng(a, 32'h2F8, 32'h2FF);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lcs_cfg_regs.sv
module lcs_cfg_regs
  import lcs_pkg::*;
#(
  parameter logic [REG_W-2:0] A_RST = 7'h04,
  parameter logic [REG_W-1:0] B_RST = 8'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-2:0] reg_a,
  output logic [REG_W-1:0] reg_b
);

  // bit 7 of register A has no function and is not stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= A_RST;
      reg_b <= B_RST;
    end else if (cfg_we) begin
      if (cfg_sel) reg_b <= cfg_wdata;
      else         reg_a <= cfg_wdata[REG_W-2:0];
    end
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (reg_a == A_RST && reg_b == B_RST));

  // R13
  write_a_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we) && !$past(cfg_sel)) |-> reg_a == $past(cfg_wdata[REG_W-2:0]));

  // R13
  write_b_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_we) && $past(cfg_sel)) |-> reg_b == $past(cfg_wdata));

endmodule

// File: rtl/lcs_decode_core.sv
module lcs_decode_core
  import lcs_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter bit KBD_ALT_PORTS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [REG_W-2:0]  reg_a,
  input  logic [REG_W-1:0]  reg_b,
  output logic [NSEL-1:0]   sel,
  output logic              ide_status_hit,
  output logic              cram_rd,
  output logic              cram_wr
);

  logic [31:0] a;
  logic        acc;
  logic        kbd_base, kbd_alt;
  logic        ide_pri, ide_sec;
  logic        cram_win;
  logic [1:0]  com_sel;

  assign a   = 32'(io_addr);
  assign acc = io_rd | io_wr;

  assign kbd_base = (a == 32'h60) || (a == 32'h64);

  generate
    if (KBD_ALT_PORTS) begin : g_kbd_alt
      assign kbd_alt = (a == 32'h62) || (a == 32'h66);
    end else begin : g_kbd_std
      assign kbd_alt = 1'b0;
    end
  endgenerate

  // one decoder per serial field: port A in B[1:0], port B in B[3:2]
  generate
    for (genvar g = 0; g < 2; g++) begin : g_com
      assign com_sel[g] = acc & com_hit(a, com_map_e'(reg_b[2*g+1 -: 2]));
    end
  endgenerate

  assign ide_pri  = in_rng(a, 32'h1F0, 32'h1F7) || (a == 32'h3F6) || (a == 32'h3F7);
  assign ide_sec  = in_rng(a, 32'h170, 32'h177) || (a == 32'h376) || (a == 32'h377);
  assign cram_win = in_rng(a, 32'h800, 32'h8FF);

  always_comb begin
    sel         = '0;
    sel[S_KBD]  = acc & reg_a[1] & (kbd_base | kbd_alt);
    sel[S_RTC]  = acc & reg_a[0] & in_rng(a, 32'h70, 32'h77);
    sel[S_IDE]  = acc & reg_a[4] & (reg_a[5] ? ide_sec : ide_pri);
    sel[S_FDC]  = acc & ((reg_a[2] & in_rng(a, 32'h3F0, 32'h3F5)) |
                         (reg_a[3] & in_rng(a, 32'h370, 32'h375)));
    sel[S_LPT]  = acc & lpt_hit(a, lpt_map_e'(reg_b[5:4]));
    sel[S_COMA] = com_sel[0];
    sel[S_COMB] = com_sel[1];
    sel[S_CRAM] = reg_b[7] & ((acc & cram_win) | (io_wr & (a == 32'hC00)));
    sel[S_P92]  = acc & reg_b[6] & (a == 32'h92);
  end

  assign ide_status_hit = acc & ((a == 32'h3F7) || (a == 32'h377));
  assign cram_rd        = reg_b[7] & io_rd & cram_win;
  assign cram_wr        = reg_b[7] & io_wr & cram_win;

  // R2
  kbd_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_a[1] |-> !sel[S_KBD]);

  // R9
  com_rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b[1:0] == 2'b10) |-> !sel[S_COMA]);

  // R10
  cram_strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cram_rd | cram_wr) |-> (io_addr[ADDR_W-1:8] == (ADDR_W-8)'(8'h08)));

  // R12
  no_access_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd | io_wr) |-> (sel == '0 && !cram_rd && !cram_wr));

endmodule

// File: rtl/lcs_xcvr_gate.sv
module lcs_xcvr_gate
  import lcs_pkg::*;
(
  input  logic            [NSEL-1:0] sel,
  input  logic                       kbd_mapped,
  input  logic                       ide_status_hit,
  output logic                       xcvr_oe
);

  logic [NSEL-1:0] pass_mask;

  always_comb begin
    pass_mask        = '1;
    pass_mask[S_KBD] = ~kbd_mapped;
  end

  assign xcvr_oe = (|(sel & pass_mask)) | ide_status_hit;

endmodule

// File: rtl/legacy_iocs_decoder.sv
module legacy_iocs_decoder
  import lcs_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter bit KBD_ALT_PORTS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic              cs_kbd,
  output logic              cs_rtc,
  output logic              cs_ide,
  output logic              cs_fdc,
  output logic              cs_lpt,
  output logic              cs_com_a,
  output logic              cs_com_b,
  output logic              cs_cram,
  output logic              cs_p92,
  output logic              xcvr_oe,
  output logic              cram_rd,
  output logic              cram_wr
);

  logic [REG_W-2:0] reg_a;
  logic [REG_W-1:0] reg_b;
  logic [NSEL-1:0]  sel;
  logic             ide_status_hit;

  lcs_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .reg_a     (reg_a),
    .reg_b     (reg_b)
  );

  lcs_decode_core #(
    .ADDR_W        (ADDR_W),
    .KBD_ALT_PORTS (KBD_ALT_PORTS)
  ) u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .io_addr        (io_addr),
    .io_rd          (io_rd),
    .io_wr          (io_wr),
    .reg_a          (reg_a),
    .reg_b          (reg_b),
    .sel            (sel),
    .ide_status_hit (ide_status_hit),
    .cram_rd        (cram_rd),
    .cram_wr        (cram_wr)
  );

  lcs_xcvr_gate u_xcvr (
    .sel            (sel),
    .kbd_mapped     (reg_a[6]),
    .ide_status_hit (ide_status_hit),
    .xcvr_oe        (xcvr_oe)
  );

  assign cs_kbd   = sel[S_KBD];
  assign cs_rtc   = sel[S_RTC];
  assign cs_ide   = sel[S_IDE];
  assign cs_fdc   = sel[S_FDC];
  assign cs_lpt   = sel[S_LPT];
  assign cs_com_a = sel[S_COMA];
  assign cs_com_b = sel[S_COMB];
  assign cs_cram  = sel[S_CRAM];
  assign cs_p92   = sel[S_P92];

  // R12
  unmapped_sel_drives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{cs_rtc, cs_ide, cs_fdc, cs_lpt, cs_com_a, cs_com_b, cs_cram, cs_p92}) |-> xcvr_oe);

  // R3
  mapped_kbd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_kbd && reg_a[6]) |-> !xcvr_oe);

  // R6
  ide_status_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd | io_wr) && (io_addr == ADDR_W'(16'h3F7) || io_addr == ADDR_W'(16'h377))) |-> xcvr_oe);

endmodule

// File: tb/test_legacy_iocs_decoder.sv
module test_legacy_iocs_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        cs_kbd, cs_rtc, cs_ide, cs_fdc, cs_lpt, cs_com_a, cs_com_b;
  logic        cs_cram, cs_p92, xcvr_oe, cram_rd, cram_wr;

  int  runs = 0, fails = 0;
  bit  done = 1'b0;
  logic [7:0] ra, rb;

  always #4 clk = ~clk;

  legacy_iocs_decoder i_legacy_iocs_decoder (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cs_kbd(cs_kbd), .cs_rtc(cs_rtc), .cs_ide(cs_ide), .cs_fdc(cs_fdc),
    .cs_lpt(cs_lpt), .cs_com_a(cs_com_a), .cs_com_b(cs_com_b), .cs_cram(cs_cram),
    .cs_p92(cs_p92), .xcvr_oe(xcvr_oe), .cram_rd(cram_rd), .cram_wr(cram_wr)
  );

  // bit order: 0 kbd,1 rtc,2 ide,3 fdc,4 lpt,5 com_a,6 com_b,7 cram,8 p92,9 oe,10 cram_rd,11 cram_wr
  string tag [12] = '{"R2", "R4", "R5", "R7", "R8", "R9", "R9", "R10", "R11", "R12", "R10", "R10"};

  function automatic bit win(int a, int lo, int hi);
    return a >= lo && a <= hi;
  endfunction

  function automatic bit com_exp(int a, logic [1:0] f);
    if (f == 2'd0) return win(a, 'h3F8, 'h3FF);
    if (f == 2'd1) return win(a, 'h2F8, 'h2FF);
    return 1'b0;
  endfunction

  function automatic logic [11:0] model(int a, logic [7:0] A, logic [7:0] B, bit rd, bit wr);
    logic [11:0] e = '0;
    bit acc = rd | wr;
    if (acc) begin
      e[0] = A[1] && (a == 'h60 || a == 'h64 || a == 'h62 || a == 'h66);
      e[1] = A[0] && win(a, 'h70, 'h77);
      if (A[4]) e[2] = A[5] ? (win(a, 'h170, 'h177) || a == 'h376 || a == 'h377)
                            : (win(a, 'h1F0, 'h1F7) || a == 'h3F6 || a == 'h3F7);
      e[3] = (A[2] && win(a, 'h3F0, 'h3F5)) || (A[3] && win(a, 'h370, 'h375));
      case (B[5:4])
        2'd0: e[4] = win(a, 'h3BC, 'h3BF);
        2'd1: e[4] = win(a, 'h378, 'h37F);
        2'd2: e[4] = win(a, 'h278, 'h27F);
        default: e[4] = 1'b0;
      endcase
      e[5] = com_exp(a, B[1:0]);
      e[6] = com_exp(a, B[3:2]);
      e[7] = B[7] && (win(a, 'h800, 'h8FF) || (wr && a == 'hC00));
      e[8] = B[6] && a == 'h92;
      e[9] = (|e[8:1]) || (e[0] && !A[6]) || a == 'h3F7 || a == 'h377;
      e[10] = B[7] && rd && win(a, 'h800, 'h8FF);
      e[11] = B[7] && wr && win(a, 'h800, 'h8FF);
    end
    return e;
  endfunction

  task automatic write_cfg(bit which, logic [7:0] d);  // R13
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = which; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (which) rb = d; else ra = {1'b0, d[6:0]};
  endtask

  task automatic probe(int a, bit rd, bit wr);
    logic [11:0] got, exp;
    @(negedge clk);
    io_addr = 16'(a); io_rd = rd; io_wr = wr;
    #3;
    got = {cram_wr, cram_rd, xcvr_oe, cs_p92, cs_cram, cs_com_b, cs_com_a,
           cs_lpt, cs_fdc, cs_ide, cs_rtc, cs_kbd};
    exp = model(a, ra, rb, rd, wr);
    runs++;
    if (got !== exp) begin
      fails++;
      for (int i = 0; i < 12; i++) begin
        if (got[i] !== exp[i]) begin
          $display("FAIL %s addr=%h rd=%0b wr=%0b A=%h B=%h got=%b exp=%b",
                   tag[i], a, rd, wr, ra, rb, got, exp);
          break;
        end
      end
    end
  endtask

  task automatic sweep(int base);
    for (int a = 0; a < 4096; a++) probe(base + a, 1'b1, 1'b0);
    for (int a = 0; a < 4096; a++) probe(base + a, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (R12) got=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    ra = 8'h04; rb = 8'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset configuration, full sweep
    sweep(0);
    // R12: nothing without a strobe
    foreach (tag[i]) probe('h60 + i, 1'b0, 1'b0);
    probe('h3F7, 1'b0, 1'b0);
    probe('h800, 1'b0, 1'b0);
    // R2 R4 R5 R8 R9: keyboard, rtc, primary IDE, lpt 3BC, both serials at 3F8
    write_cfg(1'b0, 8'h13);
    write_cfg(1'b1, 8'h00);
    sweep(0);
    // R12: no aliasing above 0FFFh
    for (int a = 0; a < 4096; a++) probe('h8000 + a, 1'b1, 1'b0);
    for (int a = 0; a < 64; a++) probe('h1060 + a, 1'b0, 1'b1);
    // R3 R5 R8 R9 R10 R11: mapped keyboard, secondary IDE, lpt 378, reserved serial B
    write_cfg(1'b0, 8'hF3);
    write_cfg(1'b1, 8'hD9);
    sweep(0);
    // R6 R7 R8 R9 R10: IDE off, both floppy ranges, lpt 278, serial B at 2F8
    write_cfg(1'b0, 8'h0C);
    write_cfg(1'b1, 8'hA6);
    sweep(0);
    // R3: mapping bit alone has no effect; R8 R9 all disabled
    write_cfg(1'b0, 8'h40);
    write_cfg(1'b1, 8'hFF);
    sweep(0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule